// File: doc/BRIEF.md
# ACPI System Control Interrupt Generator

This block holds a 16-bit power-management event status register and a matching 16-bit event enable register. It drives one level-sensitive system control interrupt (SCI) from them. Four event kinds can raise the interrupt: the power-management timer rolling over its top bit, a power-button press, a global-lock release and a real-time-clock alarm. Each has a fixed bit in both registers. The SCI stays high for as long as at least one of these four has its status bit and its enable bit both set.

A free-running power-management timer advances on a tick input. Every change of its most significant bit is a timer event. That event is recorded only while the timer enable bit is set and the timer status bit is clear. Hardware event inputs set status bits: three dedicated pulses and an auxiliary vector that can set any bit.

Software reaches the registers through a small byte-lane register port. It writes ones to clear status, it writes the enable register directly, and it reads the timer value. The port uses a 2-bit register select and two byte enables. Read data is combinational from the select.

Top module: `pm_sci_top`

## Requirements
- R1: After synchronous reset the status register, the enable register and the timer all read 0, and `sci` is 0.
- R2: A port write to select 0 (status) clears each status bit whose write-data bit is 1 within an enabled byte lane (`reg_be[0]` covers bits 7:0, `reg_be[1]` covers bits 15:8). Data bits of 0 and disabled lanes leave status unchanged.
- R3: A hardware set of a status bit in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R4: A port write to select 1 (enable) replaces only the enabled byte lanes of the enable register, and select 1 reads the register back.
- R5: `sci` goes high on the clock edge after a status bit and its enable bit are both set, for the timer bit 0, global-lock bit 5, power-button bit 8 or RTC-alarm bit 10. A pulse on `pwrbtn_evt`, `glbl_evt` or `rtc_evt` sets status bit 8, 5 or 10 respectively.
- R6: Status bits other than 0, 5, 8 and 10 never assert `sci`, even with every enable bit set. `aux_evt` sets any status bit it marks.
- R7: The timer increments by one on each clock where `tmr_tick` is 1 and wraps at 2^TMR_W. Select 2 reads timer bits 15:0 and select 3 reads bits 31:16, zero-extended.
- R8: When a tick changes timer bit TMR_W-1 (in either direction), status bit 0 is set only if enable bit 0 is 1 and status bit 0 is 0 in that cycle.
- R9: `sci` falls on the clock edge after the last qualifying status/enable pair stops being set.
- R10: Port writes to selects 2 and 3 have no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_tick | input | 1 | Timer advance strobe |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| rtc_evt | input | 1 | RTC alarm event pulse |
| glbl_evt | input | 1 | Global-lock release event pulse |
| aux_evt | input | 16 | Per-bit status set for other event sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 timer low, 3 timer high |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| sci | output | 1 | System control interrupt level |

## Verification
The status register has two writers that can act on the same bit in the same cycle: a hardware event setting it and a software write-one-to-clear. The bench drives a power-button pulse in the same clock as a clear of bit 8. It then expects the bit to read back as set and the interrupt to stay high. The timer has a second same-cycle case: a rollover landing on a tick while its enable is off or its status is already set. The bench counts ticks exactly to the top-bit change and reads status in the following cycle.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int REG_W   = 16;
    localparam int LANES   = REG_W / 8;

    localparam int BIT_TMR  = 0;
    localparam int BIT_GLBL = 5;
    localparam int BIT_PWR  = 8;
    localparam int BIT_RTC  = 10;

    typedef enum logic [1:0] {
        SEL_STS    = 2'd0,
        SEL_EN     = 2'd1,
        SEL_TMR_LO = 2'd2,
        SEL_TMR_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [LANES-1:0] be;
        logic [REG_W-1:0] data;
    } reg_req_t;

    function automatic logic [REG_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [REG_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] sci_sources();
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_TMR]  = 1'b1;
        m[BIT_GLBL] = 1'b1;
        m[BIT_PWR]  = 1'b1;
        m[BIT_RTC]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sci_pm_timer.sv
module sci_pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             top_flip
);
    localparam int TOP = TMR_W - 1;

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] cnt_nxt;

    assign cnt_nxt  = cnt_q + TMR_W'(1);
    assign top_flip = tick && (cnt_nxt[TOP] != cnt_q[TOP]);
    assign count    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/sci_evt_status.sv
module sci_evt_status
    import sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    input  logic [REG_W-1:0] hw_set,
    output logic [REG_W-1:0] sts
);
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] clr_bits;
    logic             hit;

    assign hit = req.wr && (req.sel == SEL_STS);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign clr_bits[g*8 +: 8] = (hit && req.be[g]) ? req.data[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            // a set from hardware outranks a clear from software
            sts_q <= (sts_q & ~clr_bits) | hw_set;
        end
    end

    assign sts = sts_q;
endmodule

// File: rtl/sci_evt_enable.sv
module sci_evt_enable
    import sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_req_t         req,
    output logic [REG_W-1:0] en
);
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] keep;
    logic             hit;

    assign hit  = req.wr && (req.sel == SEL_EN);
    assign keep = hit ? ~lane_mask(req.be) : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (hit) begin
            en_q <= (en_q & keep) | (req.data & ~keep);
        end
    end

    assign en = en_q;
endmodule

// File: rtl/sci_level.sv
module sci_level
    import sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    output logic             sci
);
    localparam logic [REG_W-1:0] SRC = sci_sources();

    logic pending;
    logic sci_q;

    assign pending = |(sts & en & SRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            sci_q <= 1'b0;
        end else begin
            sci_q <= pending;
        end
    end

    assign sci = sci_q;
endmodule

// File: rtl/pm_sci_top.sv
module pm_sci_top
    import sci_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tmr_tick,
    input  logic        pwrbtn_evt,
    input  logic        rtc_evt,
    input  logic        glbl_evt,
    input  logic [15:0] aux_evt,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        sci
);
    reg_req_t         req;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] hw_set;
    logic [TMR_W-1:0] tmr_cnt;
    logic [31:0]      tmr_ext;
    logic             tmr_flip;
    logic             tmr_armed;

    assign req.wr   = reg_wr;
    assign req.sel  = reg_sel_e'(reg_addr);
    assign req.be   = reg_be;
    assign req.data = reg_wdata;

    sci_pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tmr_tick),
        .count    (tmr_cnt),
        .top_flip (tmr_flip)
    );

    assign tmr_armed = en_q[BIT_TMR] && !sts_q[BIT_TMR];

    always_comb begin
        hw_set           = aux_evt;
        hw_set[BIT_TMR]  = aux_evt[BIT_TMR]  | (tmr_flip && tmr_armed);
        hw_set[BIT_GLBL] = aux_evt[BIT_GLBL] | glbl_evt;
        hw_set[BIT_PWR]  = aux_evt[BIT_PWR]  | pwrbtn_evt;
        hw_set[BIT_RTC]  = aux_evt[BIT_RTC]  | rtc_evt;
    end

    sci_evt_status u_status (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .hw_set (hw_set),
        .sts    (sts_q)
    );

    sci_evt_enable u_enable (
        .clk (clk),
        .rst (rst),
        .req (req),
        .en  (en_q)
    );

    sci_level u_level (
        .clk (clk),
        .rst (rst),
        .sts (sts_q),
        .en  (en_q),
        .sci (sci)
    );

    assign tmr_ext = 32'(tmr_cnt);

    always_comb begin
        unique case (req.sel)
            SEL_STS:    reg_rdata = sts_q;
            SEL_EN:     reg_rdata = en_q;
            SEL_TMR_LO: reg_rdata = tmr_ext[15:0];
            SEL_TMR_HI: reg_rdata = tmr_ext[31:16];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sci_chk.sv
module sci_chk #(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tmr_tick,
    input logic             pwrbtn_evt,
    input logic [15:0]      aux_evt,
    input logic [15:0]      sts,
    input logic [15:0]      en,
    input logic [TMR_W-1:0] tmr,
    input logic             sci
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sci == 1'b0 && sts == 16'h0 && en == 16'h0));

    // R3
    pwr_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pwrbtn_evt |=> sts[8]);

    // R5
    sci_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ((sts[8] && en[8]) || (sts[10] && en[10])) |=> sci);

    // R6
    sci_other_chk: assert property (@(posedge clk) disable iff (rst)
        (!(sts[0] && en[0]) && !(sts[5] && en[5]) &&
         !(sts[8] && en[8]) && !(sts[10] && en[10])) |=> !sci);

    // R7
    tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_tick |=> tmr == $past(tmr) + TMR_W'(1));

    // R8
    tmr_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        (!sts[0] && !en[0] && !aux_evt[0]) |=> !sts[0]);

    // R10
    tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_tick |=> $stable(tmr));
endmodule

bind pm_sci_top sci_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tmr_tick   (tmr_tick),
    .pwrbtn_evt (pwrbtn_evt),
    .aux_evt    (aux_evt),
    .sts        (sts_q),
    .en         (en_q),
    .tmr        (tmr_cnt),
    .sci        (sci)
);

// File: tb/pm_sci_top_test.sv
module pm_sci_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_tick = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        rtc_evt = 1'b0;
    logic        glbl_evt = 1'b0;
    logic [15:0] aux_evt = 16'h0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        sci;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_sci_top #(.TMR_W(TW)) uut (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick), .pwrbtn_evt(pwrbtn_evt),
        .rtc_evt(rtc_evt), .glbl_evt(glbl_evt), .aux_evt(aux_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sci(sci)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic test_reset();
        logic [15:0] v;
        rd(2'd0, v); check("R1 status", v, 16'h0);
        rd(2'd1, v); check("R1 enable", v, 16'h0);
        rd(2'd2, v); check("R1 timer", v, 16'h0);
        check("R1 sci", {15'h0, sci}, 16'h0);
    endtask

    task automatic test_enable_lanes();
        logic [15:0] v;
        wr(2'd1, 2'b01, 16'hFFFF);
        rd(2'd1, v); check("R4 low lane", v, 16'h00FF);
        wr(2'd1, 2'b10, 16'h1200);
        rd(2'd1, v); check("R4 high lane", v, 16'h12FF);
        wr(2'd1, 2'b11, 16'h0000);
        rd(2'd1, v); check("R4 word", v, 16'h0000);
    endtask

    task automatic test_power_button();
        logic [15:0] v;
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
        rd(2'd0, v); check("R5 pwr status", v, 16'h0100);
        @(negedge clk);
        check("R5 no sci while disabled", {15'h0, sci}, 16'h0);
        wr(2'd1, 2'b11, 16'h0100);
        @(negedge clk);
        check("R5 sci raised", {15'h0, sci}, 16'h1);
        wr(2'd0, 2'b11, 16'hFEFF);
        rd(2'd0, v); check("R2 zero bits keep", v, 16'h0100);
        wr(2'd0, 2'b01, 16'h0100);
        rd(2'd0, v); check("R2 disabled lane keeps", v, 16'h0100);
        wr(2'd0, 2'b10, 16'h0100);
        rd(2'd0, v); check("R2 clear", v, 16'h0000);
        @(negedge clk);
        check("R9 sci dropped", {15'h0, sci}, 16'h0);
    endtask

    task automatic test_rtc_glbl();
        logic [15:0] v;
        wr(2'd1, 2'b11, 16'h0420);
        @(negedge clk); rtc_evt = 1'b1; glbl_evt = 1'b1;
        @(negedge clk); rtc_evt = 1'b0; glbl_evt = 1'b0;
        rd(2'd0, v); check("R5 rtc+glbl status", v, 16'h0420);
        @(negedge clk);
        check("R5 sci rtc/glbl", {15'h0, sci}, 16'h1);
        wr(2'd0, 2'b10, 16'h0400);
        @(negedge clk);
        check("R9 sci held by glbl", {15'h0, sci}, 16'h1);
        wr(2'd0, 2'b01, 16'h0020);
        @(negedge clk);
        check("R9 sci after last clear", {15'h0, sci}, 16'h0);
    endtask

    task automatic test_aux();
        logic [15:0] v;
        wr(2'd1, 2'b11, 16'hFFFF);
        @(negedge clk); aux_evt = 16'h8002;
        @(negedge clk); aux_evt = 16'h0;
        rd(2'd0, v); check("R6 aux status", v, 16'h8002);
        repeat (2) @(negedge clk);
        check("R6 no sci", {15'h0, sci}, 16'h0);
        wr(2'd0, 2'b11, 16'hFFFF);
        wr(2'd1, 2'b11, 16'h0000);
    endtask

    task automatic test_collision();
        logic [15:0] v;
        wr(2'd1, 2'b11, 16'h0100);
        @(negedge clk); pwrbtn_evt = 1'b1;
        @(negedge clk); pwrbtn_evt = 1'b0;
        // set and clear of bit 8 in the same cycle
        @(negedge clk);
        pwrbtn_evt = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_be = 2'b11; reg_wdata = 16'h0100;
        @(negedge clk);
        pwrbtn_evt = 1'b0; reg_wr = 1'b0; reg_be = 2'b00;
        rd(2'd0, v); check("R3 set wins", v, 16'h0100);
        @(negedge clk);
        check("R3 sci stays", {15'h0, sci}, 16'h1);
        wr(2'd0, 2'b11, 16'h0100);
        wr(2'd1, 2'b11, 16'h0000);
        @(negedge clk);
        check("R9 sci low after collision", {15'h0, sci}, 16'h0);
    endtask

    task automatic test_timer();
        logic [15:0] v;
        rd(2'd2, v); check("R7 timer idle", v, 16'h0);
        wr(2'd2, 2'b11, 16'h0055);
        wr(2'd3, 2'b11, 16'hFFFF);
        rd(2'd2, v); check("R10 low not written", v, 16'h0);
        rd(2'd3, v); check("R10 high not written", v, 16'h0);
        wr(2'd1, 2'b11, 16'h0001);
        ticks(127);
        rd(2'd2, v); check("R7 count 127", v, 16'd127);
        rd(2'd0, v); check("R8 before flip", v, 16'h0);
        ticks(1);
        rd(2'd2, v); check("R7 count 128", v, 16'd128);
        rd(2'd0, v); check("R8 flip sets", v, 16'h0001);
        @(negedge clk);
        check("R5 timer sci", {15'h0, sci}, 16'h1);
        wr(2'd1, 2'b11, 16'h0000);
        wr(2'd0, 2'b11, 16'h0001);
        ticks(128);
        rd(2'd2, v); check("R7 wrapped", v, 16'h0);
        rd(2'd0, v); check("R8 disabled flip ignored", v, 16'h0);
        check("R9 timer sci low", {15'h0, sci}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_enable_lanes();
        test_power_button();
        test_rtc_glbl();
        test_aux();
        test_collision();
        test_timer();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule